// File: doc/BRIEF.md
# SPI Message Sequencer

This block walks a queue of SPI messages through a byte-wide serial engine. A message carries a clock mode and a desired clock divisor and is followed by a list of transfer descriptors. Each descriptor gives a byte count, whether bytes come from a transmit source, whether received bytes go to a receive sink, a post-transfer delay in clock cycles, and a chip-select change flag. The sequencer programs the engine once per message, issues one byte write at a time, and stores the returned byte. A write collision makes it resend the same byte. A mode fault makes it abort the message. When the message ends it raises a one-cycle completion pulse together with a status and the number of bytes finished.

The controller has four states. SEQ_IDLE waits for a message. It moves to SEQ_LOAD when it accepts one (transition *accept*). SEQ_LOAD takes the next descriptor and issues its first byte, then moves to SEQ_XFER (*launch*). SEQ_XFER stays where it is on a collision (*resend*) and after each byte that is not the last (*stream*). It goes to SEQ_WAIT on the final byte (*drain*) and back to SEQ_IDLE on a mode fault (*abort*). SEQ_WAIT holds until the delay has run out. It then either returns to SEQ_LOAD for the next descriptor (*chain*) or finishes in SEQ_IDLE (*finish*).

Top module: `spi_seq_top`

## Requirements
- R1: After reset `cs_n` is 1, `msg_status` is 1 (ok), and `msg_done`, `eng_wr`, `eng_cfg_we` and `rx_push` are 0.
- R2: In SEQ_IDLE with `msg_valid` high, the block raises `msg_ready` and pops the message. The next cycle it pulses `eng_cfg_we` with `eng_mode` equal to `msg_mode`, and `msg_status` reads 0 (busy) until completion.
- R3: `eng_rate` is {1'b0, P[2:0], 1'b0, S[2:0]}, computed from `msg_div` as follows. Start with P = (div+1)>>1, forced to at least 1, and S = 0. While (P-1) has any bit set above bit 2, set P = (P+1)>>1 and increment S. Then decrement P. If S > 7, both fields become 7.
- R4: Bytes are written one at a time, each only after the previous one completes. A transfer with a transmit source writes `tx_byte` and pulses `tx_pop` once per byte. A transfer without one writes 0x00 and never pops.
- R5: Each completion without collision or fault pulses `rx_push` with `rx_byte` equal to `eng_rdata`, but only when the transfer has a sink.
- R6: A completion with `eng_wcol` set (this takes priority over `eng_modf`) rewrites the same byte. It consumes no source byte, pushes nothing and does not count the byte.
- R7: A completion with `eng_modf` set releases `cs_n`, pulses `msg_done` with status 2 (error) and `msg_actual` equal to the bytes of transfers fully finished so far, and returns to SEQ_IDLE.
- R8: After a transfer's last byte completes, SEQ_WAIT lasts max(1, delay) cycles. For the last transfer, `msg_done` therefore appears max(1, delay)+1 cycles after the cycle in which the final `eng_done` was high.
- R9: A message without a fault ends with one `msg_done` pulse, status 1 (ok), and `msg_actual` equal to the sum of all its transfer lengths. Each length must be at least 1.
- R10: `cs_n` falls when a message's first transfer starts. Between transfers it rises, and falls again at the next start, only if the finished transfer's change flag was set. It rises when the message ends. `eng_wr` is never high while `cs_n` is 1.
- R11: An `eng_done` pulse while the sequencer is idle has no effect: no write, push, completion or chip-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | A message is pending |
| msg_ready | output | 1 | Message accepted this cycle |
| msg_mode | input | 3 | Clock mode bits, passed through to the engine |
| msg_div | input | DIV_W | Desired clock divisor |
| xd_valid | input | 1 | Transfer descriptor present |
| xd_ready | output | 1 | Descriptor accepted this cycle |
| xd_len | input | LEN_W | Byte count (at least 1) |
| xd_has_tx | input | 1 | Transfer has a transmit source |
| xd_has_rx | input | 1 | Transfer has a receive sink |
| xd_dly | input | DLY_W | Post-transfer delay in cycles |
| xd_cs_chg | input | 1 | Release chip select after this transfer |
| xd_last | input | 1 | Last transfer of the message |
| tx_byte | input | 8 | Head of the transmit source |
| tx_pop | output | 1 | Consume `tx_byte` this cycle |
| rx_push | output | 1 | `rx_byte` is valid |
| rx_byte | output | 8 | Received byte |
| eng_cfg_we | output | 1 | Load mode and rate into the engine |
| eng_mode | output | 3 | Mode to engine |
| eng_rate | output | 8 | Encoded rate to engine |
| eng_wr | output | 1 | Write one byte to the engine |
| eng_wdata | output | 8 | Byte to send |
| eng_done | input | 1 | Engine finished a byte |
| eng_rdata | input | 8 | Byte received by the engine |
| eng_wcol | input | 1 | Write collision on this completion |
| eng_modf | input | 1 | Mode fault on this completion |
| cs_n | output | 1 | Chip select, active low |
| msg_done | output | 1 | One-cycle completion pulse |
| msg_status | output | 2 | 0 busy, 1 ok, 2 error |
| msg_actual | output | LEN_W+XF_W | Bytes of finished transfers |

## Verification
The main sweep runs one-, two- and three-transfer messages. Across these messages it varies byte counts, source and sink presence, delays from 0 upward and change-flag patterns. This separates zero fill from sourced data, pushed bytes from discarded ones, and chip-select drops from held selects. Collisions are placed at the first, a middle and the final write. This shows whether a resend repeats the byte and leaves the count and source untouched. Mode faults are placed in the first and in a later transfer, which distinguishes the partial length reported from the full one. A divisor sweep with extreme values covers every rounding step and the clamp of the rate encoding.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_XFER = 2'd2,
        SEQ_WAIT = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        MSG_BUSY = 2'd0,
        MSG_OK   = 2'd1,
        MSG_ERR  = 2'd2
    } msg_stat_e;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  FILL_BYTE = 8'h00;
    localparam int          FIELD_MAX = 7;

endpackage

// File: rtl/spi_seq_rate_enc.sv
module spi_seq_rate_enc #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [7:0]       rate_o
);
    localparam int SW = $clog2(DIV_W + 2);

    logic [DIV_W:0] pre;
    logic [SW-1:0]  shf;

    // Halve the prescaler until it fits three bits, counting halvings
    always_comb begin
        pre = ({1'b0, div_i} + 1'b1) >> 1;
        if (pre == '0) begin
            pre = 1;
        end
        shf = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (((pre - 1'b1) & ~(DIV_W+1)'(7)) != '0) begin
                pre = (pre + 1'b1) >> 1;
                shf = shf + 1'b1;
            end
        end
        pre = pre - 1'b1;
        if (shf > SW'(spi_seq_pkg::FIELD_MAX)) begin
            rate_o = {1'b0, 3'd7, 1'b0, 3'd7};
        end else begin
            rate_o = {1'b0, pre[2:0], 1'b0, shf[2:0]};
        end
    end

endmodule

// File: rtl/spi_seq_delay.sv
module spi_seq_delay #(
    parameter int CNT_W = 16,
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             due_o
);
    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] dead_q;
    logic [CNT_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q  <= '0;
            dead_q <= '0;
        end else begin
            now_q <= now_q + 1'b1;
            if (arm_i) begin
                dead_q <= now_q + CNT_W'(dly_i);
            end
        end
    end

    // Signed distance keeps the compare valid across counter wrap
    always_comb begin
        diff  = now_q - dead_q;
        due_o = !diff[CNT_W-1];
    end

    p_zero_delay_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && dly_i == '0) |=> due_o)
        else $error("zero delay not due on the next cycle");

endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
    import spi_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int DLY_W = 12,
    parameter int CNT_W = 16,
    parameter int DIV_W = 16,
    parameter int XF_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   msg_valid,
    output logic                   msg_ready,
    input  logic [2:0]             msg_mode,
    input  logic [DIV_W-1:0]       msg_div,
    input  logic                   xd_valid,
    output logic                   xd_ready,
    input  logic [LEN_W-1:0]       xd_len,
    input  logic                   xd_has_tx,
    input  logic                   xd_has_rx,
    input  logic [DLY_W-1:0]       xd_dly,
    input  logic                   xd_cs_chg,
    input  logic                   xd_last,
    input  logic [7:0]             tx_byte,
    output logic                   tx_pop,
    output logic                   rx_push,
    output logic [7:0]             rx_byte,
    output logic                   eng_cfg_we,
    output logic [2:0]             eng_mode,
    output logic [7:0]             eng_rate,
    output logic                   eng_wr,
    output logic [7:0]             eng_wdata,
    input  logic                   eng_done,
    input  logic [7:0]             eng_rdata,
    input  logic                   eng_wcol,
    input  logic                   eng_modf,
    output logic                   cs_n,
    output logic                   msg_done,
    output logic [1:0]             msg_status,
    output logic [LEN_W+XF_W-1:0]  msg_actual
);
    localparam int ACT_W = LEN_W + XF_W;

    seq_state_e       st_q, st_d;
    msg_stat_e        stat_q;
    logic [LEN_W-1:0] rem_q, len_q;
    logic [DLY_W-1:0] dly_q;
    logic             src_q, snk_q, last_q, chg_pend_q;
    logic [ACT_W-1:0] act_q;
    logic [7:0]       rate_w;
    logic             due_w;
    logic             ev_wcol, ev_modf, ev_good, ev_final;
    logic [7:0]       load_byte, next_byte;

    spi_seq_rate_enc #(.DIV_W(DIV_W)) u_rate (
        .div_i  (msg_div),
        .rate_o (rate_w)
    );

    spi_seq_delay #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (ev_final),
        .dly_i (dly_q),
        .due_o (due_w)
    );

    // Engine completion decode, collision first
    always_comb begin
        ev_wcol   = (st_q == SEQ_XFER) && eng_done && eng_wcol;
        ev_modf   = (st_q == SEQ_XFER) && eng_done && !eng_wcol && eng_modf;
        ev_good   = (st_q == SEQ_XFER) && eng_done && !eng_wcol && !eng_modf;
        ev_final  = ev_good && (rem_q == LEN_W'(1));
        load_byte = xd_has_tx ? tx_byte : FILL_BYTE;
        next_byte = src_q ? tx_byte : FILL_BYTE;
    end

    // Handshakes that must coincide with the consuming edge
    always_comb begin
        msg_ready = (st_q == SEQ_IDLE) && msg_valid;
        xd_ready  = (st_q == SEQ_LOAD) && xd_valid;
        tx_pop    = (xd_ready && xd_has_tx) || (ev_good && !ev_final && src_q);
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (msg_valid) st_d = SEQ_LOAD;
            SEQ_LOAD: if (xd_valid)  st_d = SEQ_XFER;
            SEQ_XFER: begin
                if (ev_modf)       st_d = SEQ_IDLE;
                else if (ev_final) st_d = SEQ_WAIT;
            end
            SEQ_WAIT: if (due_w) st_d = last_q ? SEQ_IDLE : SEQ_LOAD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // Outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_cfg_we <= 1'b0;
            eng_mode   <= '0;
            eng_rate   <= '0;
            eng_wr     <= 1'b0;
            eng_wdata  <= '0;
            rx_push    <= 1'b0;
            rx_byte    <= '0;
            cs_n       <= 1'b1;
            msg_done   <= 1'b0;
            stat_q     <= MSG_OK;
            act_q      <= '0;
            rem_q      <= '0;
            len_q      <= '0;
            dly_q      <= '0;
            src_q      <= 1'b0;
            snk_q      <= 1'b0;
            last_q     <= 1'b0;
            chg_pend_q <= 1'b0;
        end else begin
            eng_cfg_we <= 1'b0;
            eng_wr     <= 1'b0;
            rx_push    <= 1'b0;
            msg_done   <= 1'b0;
            unique case (st_q)
                SEQ_IDLE: begin
                    if (msg_valid) begin
                        eng_cfg_we <= 1'b1;
                        eng_mode   <= msg_mode;
                        eng_rate   <= rate_w;
                        chg_pend_q <= 1'b1;
                        stat_q     <= MSG_BUSY;
                        act_q      <= '0;
                    end
                end
                SEQ_LOAD: begin
                    if (xd_valid) begin
                        len_q      <= xd_len;
                        rem_q      <= xd_len;
                        dly_q      <= xd_dly;
                        src_q      <= xd_has_tx;
                        snk_q      <= xd_has_rx;
                        last_q     <= xd_last;
                        chg_pend_q <= xd_cs_chg;
                        if (chg_pend_q) cs_n <= 1'b0;
                        eng_wr     <= 1'b1;
                        eng_wdata  <= load_byte;
                    end
                end
                SEQ_XFER: begin
                    if (ev_wcol) begin
                        eng_wr <= 1'b1;
                    end else if (ev_modf) begin
                        cs_n     <= 1'b1;
                        msg_done <= 1'b1;
                        stat_q   <= MSG_ERR;
                    end else if (ev_good) begin
                        if (snk_q) begin
                            rx_push <= 1'b1;
                            rx_byte <= eng_rdata;
                        end
                        rem_q <= rem_q - 1'b1;
                        if (!ev_final) begin
                            eng_wr    <= 1'b1;
                            eng_wdata <= next_byte;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (due_w) begin
                        act_q <= act_q + ACT_W'(len_q);
                        if (last_q) begin
                            cs_n     <= 1'b1;
                            msg_done <= 1'b1;
                            stat_q   <= MSG_OK;
                        end else if (chg_pend_q) begin
                            cs_n <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign msg_status = stat_q;
    assign msg_actual = act_q;

    p_cs_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wr |-> !cs_n)
        else $error("byte written with chip select released");

    p_cfg_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |=> (eng_cfg_we && msg_status == MSG_BUSY))
        else $error("accepted message not configured");

    p_resend_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wcol |=> (eng_wr && $stable(eng_wdata) && !rx_push))
        else $error("collision not answered by a resend");

    p_fault_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_modf |=> (cs_n && msg_done && msg_status == MSG_ERR))
        else $error("mode fault not reported");

    p_push_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(eng_done))
        else $error("receive push without completion");

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_IDLE && eng_done) |=> (!rx_push && !msg_done && !eng_wr))
        else $error("idle completion had an effect");

    p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msg_done, eng_wr, eng_cfg_we}))
        else $error("overlapping sequencer strobes");

endmodule

// File: tb/sim_spi_seq_top.sv
module sim_spi_seq_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_P = 10;
    localparam int LAT   = 2;
    localparam int LEN_W = 8, DLY_W = 12, DIV_W = 16, XF_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic msg_valid = 1'b0, msg_ready;
    logic [2:0] msg_mode = '0;
    logic [DIV_W-1:0] msg_div = '0;
    logic xd_valid, xd_ready, xd_has_tx, xd_has_rx, xd_cs_chg, xd_last;
    logic [LEN_W-1:0] xd_len;
    logic [DLY_W-1:0] xd_dly;
    logic [7:0] tx_byte, rx_byte, eng_rate, eng_wdata;
    logic [7:0] eng_rdata = '0;
    logic tx_pop, rx_push, eng_cfg_we, eng_wr, cs_n, msg_done;
    logic eng_done = 1'b0, eng_wcol = 1'b0, eng_modf = 1'b0;
    logic [2:0] eng_mode;
    logic [1:0] msg_status;
    logic [LEN_W+XF_W-1:0] msg_actual;

    int xl[8], xt[8], xr[8], xdl[8], xc[8];
    int nx = 0, xoff = 0, xi = 0, pops = 0;
    logic [7:0] tx_cnt = '0;
    int checks = 0, errors = 0;
    int cyc = 0, cd = 0, pend_idx = -1, wc_at = -1, mf_at = -1;
    logic [7:0] last_w = '0;
    int wlog[64], rlog[64];
    int wn = 0, rn = 0, cs_falls = 0, cs_rises = 0, cs_bad = 0;
    logic cs_prev = 1'b1;
    bit got_done = 0, cfg_seen = 0, spur = 0, finished = 0;
    int done_cyc = 0, dset_cyc = 0, d_stat = 0, d_act = 0, c_mode = 0, c_rate = 0;

    assign xd_valid  = rst_n && ((xi - xoff) < nx);
    assign xd_len    = LEN_W'(xl[(xi - xoff) & 7]);
    assign xd_has_tx = xt[(xi - xoff) & 7] != 0;
    assign xd_has_rx = xr[(xi - xoff) & 7] != 0;
    assign xd_dly    = DLY_W'(xdl[(xi - xoff) & 7]);
    assign xd_cs_chg = xc[(xi - xoff) & 7] != 0;
    assign xd_last   = (xi - xoff) == nx - 1;
    assign tx_byte   = tx_cnt;

    spi_seq_top #(.LEN_W(LEN_W), .DLY_W(DLY_W), .DIV_W(DIV_W), .XF_W(XF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_mode(msg_mode), .msg_div(msg_div), .xd_valid(xd_valid), .xd_ready(xd_ready),
        .xd_len(xd_len), .xd_has_tx(xd_has_tx), .xd_has_rx(xd_has_rx), .xd_dly(xd_dly),
        .xd_cs_chg(xd_cs_chg), .xd_last(xd_last), .tx_byte(tx_byte), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .eng_cfg_we(eng_cfg_we), .eng_mode(eng_mode),
        .eng_rate(eng_rate), .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_done(eng_done),
        .eng_rdata(eng_rdata), .eng_wcol(eng_wcol), .eng_modf(eng_modf), .cs_n(cs_n),
        .msg_done(msg_done), .msg_status(msg_status), .msg_actual(msg_actual)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    // Consumers of the combinational handshakes
    always @(posedge clk) begin
        if (msg_ready) pops <= pops + 1;
        if (xd_ready)  xi <= xi + 1;
        if (tx_pop)    tx_cnt <= tx_cnt + 1'b1;
    end

    // Monitor and engine model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cs_n !== cs_prev) begin
            if (!cs_n) cs_falls++; else cs_rises++;
            cs_prev = cs_n;
        end
        if (eng_cfg_we) begin cfg_seen = 1; c_mode = eng_mode; c_rate = eng_rate; end
        if (rx_push) begin rlog[rn & 63] = rx_byte; rn++; end
        if (msg_done) begin got_done = 1; done_cyc = cyc; d_stat = msg_status; d_act = msg_actual; end
        if (eng_done) begin eng_done = 0; eng_wcol = 0; eng_modf = 0; end
        if (spur) begin eng_done = 1; eng_rdata = 8'h3C; spur = 0; end
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                eng_done = 1;
                eng_wcol = (pend_idx == wc_at);
                eng_modf = (pend_idx == mf_at);
                eng_rdata = last_w ^ 8'hA5;
                dset_cyc = cyc;
            end
        end
        if (eng_wr) begin
            if (cs_n) cs_bad++;
            wlog[wn & 63] = eng_wdata;
            last_w = eng_wdata;
            pend_idx = wn;
            wn++;
            cd = LAT;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rate(input int d);
        int p, s;
        p = (d + 1) >> 1;
        if (p < 1) p = 1;
        s = 0;
        while (((p - 1) & ~7) != 0) begin p = (p + 1) >> 1; s++; end
        p--;
        if (s > 7) begin p = 7; s = 7; end
        return p * 16 + s;
    endfunction

    task automatic run_msg(input int n, input int mode, input int div,
                           input int wc, input int mf, input string tag);
        int ew[64], er[64];
        int en, ern, err, act, falls, t, lastd, cur, v, p0, mism, gap;
        bit again;
        @(posedge clk); #1;
        wn = 0; rn = 0; cs_falls = 0; cs_rises = 0; cs_bad = 0;
        got_done = 0; cfg_seen = 0; wc_at = wc; mf_at = mf;
        nx = n; xoff = xi; t = tx_cnt;
        en = 0; ern = 0; err = 0; act = 0; falls = 1; lastd = 0;
        for (int i = 0; i < n && err == 0; i++) begin
            for (int b = 0; b < xl[i] && err == 0; b++) begin
                v = (xt[i] != 0) ? (t & 255) : 0;
                if (xt[i] != 0) t++;
                again = 1;
                while (again) begin
                    cur = en; ew[en] = v; en++;
                    if (cur == wc) again = 1;
                    else begin
                        again = 0;
                        if (cur == mf) err = 1;
                        else if (xr[i] != 0) begin er[ern] = v ^ 8'hA5; ern++; end
                    end
                end
            end
            if (err == 0) begin
                act += xl[i];
                if (i < n - 1 && xc[i] != 0) falls++;
                lastd = xdl[i];
            end
        end
        msg_mode = 3'(mode); msg_div = DIV_W'(div);
        p0 = pops; msg_valid = 1;
        t = 0;
        while (pops == p0 && t < 100) begin @(negedge clk); t++; end
        msg_valid = 0;
        chk(msg_status == 2'd0, {tag, " R2 busy status"}, msg_status, 0);
        t = 0;
        while (!got_done && t < 3000) begin @(negedge clk); t++; end
        chk(got_done, {tag, " R9 completion pulse"}, got_done, 1);
        chk(cfg_seen && c_mode == mode, {tag, " R2 mode passthrough"}, c_mode, mode);
        chk(c_rate == exp_rate(div), {tag, " R3 rate encoding"}, c_rate, exp_rate(div));
        chk(wn == en, {tag, " R4 write count"}, wn, en);
        mism = 0;
        for (int k = 0; k < en && k < wn; k++) if (wlog[k] != ew[k]) mism++;
        chk(mism == 0, {tag, " R4 written bytes"}, mism, 0);
        chk(rn == ern, {tag, " R5 push count"}, rn, ern);
        mism = 0;
        for (int k = 0; k < ern && k < rn; k++) if (rlog[k] != er[k]) mism++;
        chk(mism == 0, {tag, " R5 pushed bytes"}, mism, 0);
        chk(d_stat == (err ? 2 : 1), {tag, " R7 R9 status"}, d_stat, err ? 2 : 1);
        chk(d_act == act, {tag, " R7 R9 actual length"}, d_act, act);
        chk(cs_falls == falls && cs_rises == falls, {tag, " R10 chip select edges"},
            cs_falls * 100 + cs_rises, falls * 100 + falls);
        chk(cs_bad == 0 && cs_n == 1'b1, {tag, " R10 select during writes"}, cs_bad, 0);
        if (err == 0) begin
            gap = ((lastd < 1) ? 1 : lastd) + 1;
            chk(done_cyc - dset_cyc == gap, {tag, " R8 delay timing"}, done_cyc - dset_cyc, gap);
        end
    endtask

    task automatic set_x(input int i, input int len, input int tx, input int rx,
                         input int dly, input int chg);
        xl[i] = len; xt[i] = tx; xr[i] = rx; xdl[i] = dly; xc[i] = chg;
    endtask

    initial begin
        int rn0, wn0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && msg_status == 2'd1 && !msg_done && !eng_wr && !eng_cfg_we && !rx_push,
            "R1 reset state", {cs_n, msg_status}, 3'b101);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1 && msg_status == 2'd1, "R1 after reset release", {cs_n, msg_status}, 3'b101);

        // Main sweep over transfer shapes
        for (int n = 1; n <= 3; n++) begin
            for (int pat = 0; pat < 8; pat++) begin
                for (int i = 0; i < 3; i++)
                    set_x(i, 1 + ((pat + i * 3) % 4), (pat ^ i) & 1, ((pat >> 1) + i) & 1,
                          (pat * 5 + i * 3) % 7, ((pat >> 2) ^ i) & 1);
                run_msg(n, pat, pat * 37 + n, -1, -1, "sweep R4 R5 R10");
            end
        end

        // Collisions at first, middle and final write
        set_x(0, 3, 1, 1, 2, 1); set_x(1, 2, 0, 1, 0, 0);
        run_msg(2, 3, 20, 0, -1, "R6 collision first");
        run_msg(2, 3, 20, 2, -1, "R6 collision middle");
        run_msg(2, 3, 20, 4, -1, "R6 collision final");
        run_msg(2, 1, 20, 1, 3, "R6 R7 collision then fault");

        // Mode faults in first and later transfer
        run_msg(2, 2, 9, -1, 1, "R7 fault first transfer");
        set_x(0, 2, 1, 0, 3, 0); set_x(1, 3, 1, 1, 1, 1); set_x(2, 2, 0, 1, 4, 0);
        run_msg(3, 5, 9, -1, 6, "R7 fault later transfer");
        run_msg(3, 5, 9, -1, -1, "R9 R10 three transfers held select");

        // Long delays
        set_x(0, 1, 1, 1, 40, 1); set_x(1, 2, 0, 0, 17, 0);
        run_msg(2, 0, 3, -1, -1, "R8 long delays");

        // Spurious completion while idle
        @(posedge clk); #1;
        got_done = 0; rn0 = rn; wn0 = wn;
        spur = 1;
        repeat (6) @(negedge clk);
        chk(rn == rn0 && wn == wn0 && !got_done && cs_n == 1'b1 && msg_status == 2'd1,
            "R11 idle completion ignored", rn - rn0 + wn - wn0, 0);

        // Divisor sweep for the rate encoding
        set_x(0, 1, 0, 0, 0, 0);
        for (int d = 0; d < 300; d += 3) run_msg(1, d & 7, d, -1, -1, "R3 divisor sweep");
        run_msg(1, 0, 65535, -1, -1, "R3 clamp max");
        run_msg(1, 0, 4095, -1, -1, "R3 large");
        run_msg(1, 0, 1000, -1, -1, "R3 mid");
        run_msg(1, 0, 17, -1, -1, "R3 one halving");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule